// File: doc/BRIEF.md
# Processor Interrupt and Timer Unit

This unit gives a small in-order core its interrupt machinery. The core hands it already-decoded custom commands: a major opcode, a 7-bit function code, a register operand, a flag telling whether that operand came from register zero, a 2-bit scratch-register index and the address of the command. The unit answers each command with a one-cycle result pulse carrying a 32-bit return value and, for control-flow commands, a new program counter. It holds a 32-bit source mask, sticky pending bits, a down-counting cycle timer, a global enable flag and four scratch registers, the first two of which receive the return address and the taken sources when a handler is entered.

Sources are numbered from bit 0 upward: the timer, an illegal-instruction fault, a bus fault, then 29 external request lines. Whenever interrupts are enabled, no command is being presented and an unmasked source is pending, the unit diverts the core to a fixed handler vector. A wait command holds the core stalled until some unmasked source is pending. A fault whose own source bit is masked cannot be handled, so it stops the core through a sticky halt output.

Top module: `ictl_unit`

## Requirements
- R1: Only commands with major opcode 7'b0001011 are accepted; any other opcode produces no result and changes no state. Function codes: 0 read scratch register, 1 write scratch register, 2 return from interrupt, 3 swap mask, 4 wait, 5 swap timer; any other code returns 0.
- R2: Every accepted command other than a stalling wait raises resp_valid_o for one cycle, one clock edge after the edge that accepts it.
- R3: The swap-mask command loads the operand into the mask and returns the previous mask. A set mask bit disables that source. After reset the mask is all ones.
- R4: A nonzero timer count decrements once per clock; on the step from 1 to 0 it sets pending bit 0, so a count of N loaded at one edge sets the bit at the Nth edge after it. A count of zero stays at zero and never fires.
- R5: The swap-timer command returns the count held just before the load; when the operand came from register zero the timer is loaded with zero.
- R6: Four scratch registers are read and written by a 2-bit index; a write returns the value written.
- R7: Wait returns the unmasked pending bits when any are set, with a program-counter load of the command address plus 4. Otherwise stall_o is high and no result is given until an unmasked source is pending; masked sources do not end the stall.
- R8: An illegal-instruction fault while mask bit 1 is set, or a bus fault while mask bit 2 is set, raises halt_o, which stays high until reset. An unmasked fault does not halt.
- R9: With the enable flag set, no command presented, no wait stalled and an unmasked source pending, the unit pulses irq_take_o, stores core_pc_i in scratch register 0, stores the taken bits in scratch register 1, clears those pending bits and clears the enable flag.
- R10: Return from interrupt loads the program counter with scratch register 0 and sets the enable flag; the flag is set after reset.
- R11: Pending bits are sticky: bit 1 illegal fault, bit 2 bus fault, bit 3+i external line i; a one-cycle pulse is remembered until a handler entry takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command presented this cycle |
| cmd_opcode_i | input | 7 | Major opcode of the command |
| cmd_func_i | input | 7 | Function code |
| cmd_operand_i | input | 32 | Source register value |
| cmd_src_zero_i | input | 1 | Source register is register zero |
| cmd_qidx_i | input | 2 | Scratch register index |
| cmd_pc_i | input | 32 | Address of the command |
| core_pc_i | input | 32 | Return address to save on handler entry |
| ext_irq_i | input | 29 | External interrupt request lines |
| fault_ill_i | input | 1 | Illegal-instruction fault pulse |
| fault_bus_i | input | 1 | Bus fault pulse |
| resp_valid_o | output | 1 | One-cycle result pulse |
| resp_data_o | output | 32 | Result value |
| resp_pc_load_o | output | 1 | Result carries a new program counter |
| resp_pc_o | output | 32 | New program counter |
| stall_o | output | 1 | Core held by a wait command |
| irq_take_o | output | 1 | Handler entry pulse |
| irq_vector_o | output | 32 | Handler address |
| halt_o | output | 1 | Sticky halt on a masked fault |

## Verification
The bench times the timer to the exact edge: a load of 5 must produce a handler entry six edges later, so a design that fires on reaching 1 instead of leaving it, or one that keeps firing at zero, shows an early or extra entry. Swap commands are issued back to back so that a design returning the new value, or reading the timer after its decrement, returns the wrong old value. During a stalled wait a masked source is raised; a design that wakes on any pending bit gives a result too early. Faults are raised under both mask settings, which catches a halt tied to the wrong mask bit or polarity.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  localparam int unsigned XLEN = 32;
  localparam logic [6:0]  OPC_CUSTOM = 7'b0001011;

  localparam logic [6:0] FN_GETQ  = 7'd0;
  localparam logic [6:0] FN_SETQ  = 7'd1;
  localparam logic [6:0] FN_RETI  = 7'd2;
  localparam logic [6:0] FN_MASK  = 7'd3;
  localparam logic [6:0] FN_WAIT  = 7'd4;
  localparam logic [6:0] FN_TIMER = 7'd5;

  // Next timer count: saturates at zero.
  function automatic logic [XLEN-1:0] timer_step(input logic [XLEN-1:0] cnt);
    return (cnt == '0) ? '0 : cnt - 1'b1;
  endfunction

  // The step from one to zero is the only firing step.
  function automatic logic timer_fires(input logic [XLEN-1:0] cnt);
    return cnt == {{(XLEN-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [XLEN-1:0] resume_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

endpackage

// File: rtl/ictl_timer.sv
module ictl_timer
  import ictl_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         fire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= timer_step(cnt_q);
  end

  assign cnt_o  = cnt_q;
  assign fire_o = timer_fires(cnt_q) && !load_i;

  p_fire_lands_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_o == '0));

  p_idle_stays_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !load_i) |=> (cnt_o == '0));

endmodule

// File: rtl/ictl_pending.sv
module ictl_pending #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] clear_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clear_i) | event_i;
  end

  assign pend_o = pend_q;

  p_sticky_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  p_taken_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i != '0) |=> ((pend_o & $past(clear_i) & ~$past(event_i)) == '0));

endmodule

// File: rtl/ictl_unit.sv
module ictl_unit
  import ictl_pkg::*;
#(
  parameter int unsigned   NUM_Q       = 4,
  parameter logic [31:0]   HANDLER_VEC = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid_i,
  input  logic [6:0]  cmd_opcode_i,
  input  logic [6:0]  cmd_func_i,
  input  logic [31:0] cmd_operand_i,
  input  logic        cmd_src_zero_i,
  input  logic [1:0]  cmd_qidx_i,
  input  logic [31:0] cmd_pc_i,
  input  logic [31:0] core_pc_i,
  input  logic [28:0] ext_irq_i,
  input  logic        fault_ill_i,
  input  logic        fault_bus_i,
  output logic        resp_valid_o,
  output logic [31:0] resp_data_o,
  output logic        resp_pc_load_o,
  output logic [31:0] resp_pc_o,
  output logic        stall_o,
  output logic        irq_take_o,
  output logic [31:0] irq_vector_o,
  output logic        halt_o
);

  localparam int unsigned QW    = $clog2(NUM_Q);
  localparam int unsigned EXT_N = XLEN - 3;

  logic [XLEN-1:0] qreg_q [NUM_Q];
  logic [XLEN-1:0] mask_q;
  logic [XLEN-1:0] wait_pc_q;
  logic            en_q;
  logic            wait_q;
  logic            halt_q;

  // Named internal events
  logic            accept;
  logic            take;
  logic            tmr_load;
  logic            tmr_fire;
  logic [XLEN-1:0] tmr_cnt;
  logic [XLEN-1:0] pend;
  logic [XLEN-1:0] active;
  logic [XLEN-1:0] events;
  logic [XLEN-1:0] clear;
  logic [QW-1:0]   qidx;

  assign qidx     = cmd_qidx_i[QW-1:0];
  assign accept   = cmd_valid_i && (cmd_opcode_i == OPC_CUSTOM) && !wait_q;
  assign active   = pend & ~mask_q;
  assign take     = en_q && (active != '0) && !cmd_valid_i && !wait_q;
  assign tmr_load = accept && (cmd_func_i == FN_TIMER);
  assign events   = {ext_irq_i[EXT_N-1:0], fault_bus_i, fault_ill_i, tmr_fire};
  assign clear    = take ? active : '0;

  ictl_timer #(.W(XLEN)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (cmd_src_zero_i ? '0 : cmd_operand_i),
    .cnt_o      (tmr_cnt),
    .fire_o     (tmr_fire)
  );

  ictl_pending #(.W(XLEN)) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (events),
    .clear_i (clear),
    .pend_o  (pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) qreg_q[i] <= '0;
      mask_q         <= '1;
      wait_pc_q      <= '0;
      en_q           <= 1'b1;
      wait_q         <= 1'b0;
      halt_q         <= 1'b0;
      resp_valid_o   <= 1'b0;
      resp_data_o    <= '0;
      resp_pc_load_o <= 1'b0;
      resp_pc_o      <= '0;
      irq_take_o     <= 1'b0;
    end else begin
      resp_valid_o   <= 1'b0;
      resp_pc_load_o <= 1'b0;
      irq_take_o     <= 1'b0;
      halt_q <= halt_q | (fault_ill_i & mask_q[1]) | (fault_bus_i & mask_q[2]);

      if (accept) begin
        resp_valid_o <= 1'b1;
        resp_data_o  <= '0;
        case (cmd_func_i)
          FN_GETQ:  resp_data_o <= qreg_q[qidx];
          FN_SETQ: begin
            qreg_q[qidx] <= cmd_operand_i;
            resp_data_o  <= cmd_operand_i;
          end
          FN_RETI: begin
            en_q           <= 1'b1;
            resp_pc_load_o <= 1'b1;
            resp_pc_o      <= qreg_q[0];
          end
          FN_MASK: begin
            mask_q      <= cmd_operand_i;
            resp_data_o <= mask_q;
          end
          FN_WAIT: begin
            if (active != '0) begin
              resp_data_o    <= active;
              resp_pc_load_o <= 1'b1;
              resp_pc_o      <= resume_addr(cmd_pc_i);
            end else begin
              resp_valid_o <= 1'b0;
              wait_q       <= 1'b1;
              wait_pc_q    <= resume_addr(cmd_pc_i);
            end
          end
          FN_TIMER: resp_data_o <= tmr_cnt;
          default:  resp_data_o <= '0;
        endcase
      end else if (wait_q && (active != '0)) begin
        wait_q         <= 1'b0;
        resp_valid_o   <= 1'b1;
        resp_data_o    <= active;
        resp_pc_load_o <= 1'b1;
        resp_pc_o      <= wait_pc_q;
      end

      if (take) begin
        qreg_q[0]  <= core_pc_i;
        qreg_q[1]  <= active;
        en_q       <= 1'b0;
        irq_take_o <= 1'b1;
      end
    end
  end

  assign stall_o      = wait_q;
  assign halt_o       = halt_q;
  assign irq_vector_o = HANDLER_VEC;

  p_stall_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !resp_valid_o);

  p_entry_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> !en_q);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  p_reti_enables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_func_i == FN_RETI) |=> en_q);

  p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_opcode_i != OPC_CUSTOM && !wait_q) |=> !resp_valid_o);

endmodule

// File: tb/ictl_unit_bench.sv
module ictl_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [6:0]  cmd_opcode;
  logic [6:0]  cmd_func;
  logic [31:0] cmd_operand;
  logic        cmd_src_zero;
  logic [1:0]  cmd_qidx;
  logic [31:0] cmd_pc;
  logic [31:0] core_pc;
  logic [28:0] ext_irq;
  logic        fault_ill;
  logic        fault_bus;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        resp_pc_load;
  logic [31:0] resp_pc;
  logic        stall;
  logic        irq_take;
  logic [31:0] irq_vector;
  logic        halt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [6:0] CUST = 7'b0001011;
  localparam logic [31:0] VEC = 32'h0000_0010;

  always #4 clk = ~clk;

  ictl_unit u_ictl_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_opcode_i(cmd_opcode),
    .cmd_func_i(cmd_func), .cmd_operand_i(cmd_operand), .cmd_src_zero_i(cmd_src_zero),
    .cmd_qidx_i(cmd_qidx), .cmd_pc_i(cmd_pc), .core_pc_i(core_pc), .ext_irq_i(ext_irq),
    .fault_ill_i(fault_ill), .fault_bus_i(fault_bus), .resp_valid_o(resp_valid),
    .resp_data_o(resp_data), .resp_pc_load_o(resp_pc_load), .resp_pc_o(resp_pc),
    .stall_o(stall), .irq_take_o(irq_take), .irq_vector_o(irq_vector), .halt_o(halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one command at the current negedge; return at the next negedge.
  task automatic issue(input logic [6:0] opc, input logic [6:0] fn, input logic [31:0] opnd,
                       input logic srcz, input logic [1:0] qi, input logic [31:0] pc);
    cmd_valid = 1'b1; cmd_opcode = opc; cmd_func = fn; cmd_operand = opnd;
    cmd_src_zero = srcz; cmd_qidx = qi; cmd_pc = pc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 no result after reset", {31'b0, resp_valid}, 32'd0);
    chk("R7 no stall after reset", {31'b0, stall}, 32'd0);
    chk("R8 no halt after reset", {31'b0, halt}, 32'd0);
    chk("R9 no entry after reset", {31'b0, irq_take}, 32'd0);
    issue(CUST, 7'd3, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0);
    chk("R3 reset mask all ones", resp_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_decode;
    issue(7'b0110011, 7'd3, 32'h0, 1'b0, 2'd0, 32'h0);
    chk("R1 foreign opcode gives no result", {31'b0, resp_valid}, 32'd0);
    issue(CUST, 7'd3, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0);
    chk("R1 foreign opcode left mask", resp_data, 32'hFFFF_FFFF);
    issue(CUST, 7'd9, 32'h1234_5678, 1'b0, 2'd0, 32'h0);
    chk("R2 unknown code answered", {31'b0, resp_valid}, 32'd1);
    chk("R1 unknown code returns zero", resp_data, 32'd0);
    @(negedge clk);
    chk("R2 result is one cycle", {31'b0, resp_valid}, 32'd0);
  endtask

  task automatic t_qregs;
    issue(CUST, 7'd1, 32'h0000_00A5, 1'b0, 2'd2, 32'h0);
    chk("R6 write returns value", resp_data, 32'h0000_00A5);
    issue(CUST, 7'd0, 32'h0, 1'b0, 2'd2, 32'h0);
    chk("R6 read back q2", resp_data, 32'h0000_00A5);
    issue(CUST, 7'd0, 32'h0, 1'b0, 2'd3, 32'h0);
    chk("R6 q3 untouched", resp_data, 32'h0);
  endtask

  task automatic t_timer_swap;
    issue(CUST, 7'd5, 32'd100, 1'b0, 2'd0, 32'h0);
    chk("R5 first load returns idle count", resp_data, 32'd0);
    issue(CUST, 7'd5, 32'd77, 1'b1, 2'd0, 32'h0);
    chk("R5 old count before decrement", resp_data, 32'd100);
    issue(CUST, 7'd5, 32'd0, 1'b0, 2'd0, 32'h0);
    chk("R5 register zero loads zero", resp_data, 32'd0);
  endtask

  task automatic t_timer_fire;
    issue(CUST, 7'd3, 32'hFFFF_FFFE, 1'b0, 2'd0, 32'h0);
    chk("R3 swap returns old mask", resp_data, 32'hFFFF_FFFF);
    core_pc = 32'h0000_0200;
    repeat (3) @(negedge clk);
    chk("R4 zero count never fires", {31'b0, irq_take}, 32'd0);
    issue(CUST, 7'd5, 32'd5, 1'b0, 2'd0, 32'h0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 5) chk("R4 no fire before 1-to-0 step", {31'b0, irq_take}, 32'd0);
      if (k == 6) begin
        chk("R4 R9 entry after timer step", {31'b0, irq_take}, 32'd1);
        chk("R9 handler vector", irq_vector, VEC);
      end
    end
    @(negedge clk);
    chk("R9 entry is a pulse", {31'b0, irq_take}, 32'd0);
    issue(CUST, 7'd0, 32'h0, 1'b0, 2'd1, 32'h0);
    chk("R9 q1 holds taken bits", resp_data, 32'h1);
    issue(CUST, 7'd0, 32'h0, 1'b0, 2'd0, 32'h0);
    chk("R9 q0 holds return pc", resp_data, 32'h0000_0200);
  endtask

  task automatic t_wait_now;
    issue(CUST, 7'd3, ~32'h21, 1'b0, 2'd0, 32'h0);
    ext_irq[2] = 1'b1;
    @(negedge clk);
    ext_irq[2] = 1'b0;
    repeat (2) @(negedge clk);
    issue(CUST, 7'd4, 32'h0, 1'b0, 2'd0, 32'h0000_0300);
    chk("R11 R7 pulse kept, wait returns it", resp_data, 32'h20);
    chk("R7 wait loads pc", {31'b0, resp_pc_load}, 32'd1);
    chk("R7 resume at pc+4", resp_pc, 32'h0000_0304);
    issue(CUST, 7'd2, 32'h0, 1'b0, 2'd0, 32'h0);
    chk("R10 return loads q0", resp_pc, 32'h0000_0200);
    @(negedge clk);
    chk("R10 R9 re-enabled entry", {31'b0, irq_take}, 32'd1);
    issue(CUST, 7'd0, 32'h0, 1'b0, 2'd1, 32'h0);
    chk("R9 q1 holds external bit", resp_data, 32'h20);
  endtask

  task automatic t_wait_stall;
    bit seen = 1'b0;
    issue(CUST, 7'd4, 32'h0, 1'b0, 2'd0, 32'h0000_0400);
    chk("R7 empty wait gives no result", {31'b0, resp_valid}, 32'd0);
    chk("R7 empty wait stalls", {31'b0, stall}, 32'd1);
    ext_irq[3] = 1'b1;
    @(negedge clk);
    ext_irq[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 masked source keeps stall", {31'b0, stall}, 32'd1);
    chk("R7 masked source no result", {31'b0, resp_valid}, 32'd0);
    ext_irq[2] = 1'b1;
    @(negedge clk);
    ext_irq[2] = 1'b0;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(negedge clk);
      if (resp_valid) begin
        seen = 1'b1;
        chk("R7 stalled wait returns bits", resp_data, 32'h20);
        chk("R7 stalled wait resume pc", resp_pc, 32'h0000_0404);
      end
    end
    chk("R7 stall released", {31'b0, seen}, 32'd1);
    chk("R7 stall low after release", {31'b0, stall}, 32'd0);
  endtask

  task automatic t_faults;
    issue(CUST, 7'd3, ~32'h25, 1'b0, 2'd0, 32'h0);
    chk("R3 swap returns previous", resp_data, ~32'h21);
    fault_bus = 1'b1;
    @(negedge clk);
    fault_bus = 1'b0;
    chk("R8 unmasked fault no halt", {31'b0, halt}, 32'd0);
    fault_ill = 1'b1;
    @(negedge clk);
    fault_ill = 1'b0;
    chk("R8 masked fault halts", {31'b0, halt}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 halt sticky", {31'b0, halt}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_opcode = '0; cmd_func = '0; cmd_operand = '0;
    cmd_src_zero = 1'b0; cmd_qidx = '0; cmd_pc = '0; core_pc = '0; ext_irq = '0;
    fault_ill = 1'b0; fault_bus = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_qregs();
    t_timer_swap();
    t_timer_fire();
    t_wait_now();
    t_wait_stall();
    t_faults();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule